// File: doc/BRIEF.md
# Access-frozen tick counter

This block keeps a 24-bit binary count that goes up by one on each tick strobe from a prescaler. A serial-bus controller reads and loads the count. While the controller reports an access in progress, the count is held still, so a multi-byte read-back always sees one consistent value. A tick that arrives during the access is not lost. It is parked and applied as soon as the access ends. Only one tick can be parked. A further tick during the same access is discarded and recorded in a sticky flag.

Loads arrive a byte at a time, most significant byte first, after the bus decoder signals the start of a load. Each byte is committed whole, on its own strobe. If the transfer stops early, only the bytes already received change. An increment strobe is raised in the same cycle that the incremented value first shows on the count output, so a wake-up pulse derived from it always sees the new value.

Top module: `frozen_tick_counter`

## Requirements
- R1: While reset is asserted and after it is released, the count reads 000000h and both the increment strobe and the lost-tick flag are low.
- R2: A tick with the access flag low makes the count one higher in the next cycle. The increment strobe is high in that same cycle only. FFFFFFh is followed by 000000h.
- R3: While the access flag is high, the count changes only through byte loads, and the increment strobe stays low.
- R4: The first tick that arrives during an access is held. The count rises by one in the cycle after the first cycle in which the access flag is low.
- R5: A tick that arrives during an access while one is already held is dropped. The lost-tick flag then goes high and stays high until reset.
- R6: A single low cycle of the access flag between two accesses is enough to apply a held tick.
- R7: After a load-start strobe in an access, successive byte strobes write bits 23:16, then 15:8, then 7:0. Each byte is visible in the cycle after its strobe. Bytes that were not received keep their value.
- R8: A byte strobe is ignored when it is the fourth or a later byte after a start, when no start came earlier in the same access, or when the access flag is low.
- R9: A tick held during an access survives a load in that access. The increment is applied to the loaded value when the access ends.
- R10: When a new tick coincides with the release of a held tick, the count rises by one. The new tick is then held and applied in the next cycle if the access flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle tick strobe from the prescaler |
| access_i | input | 1 | High while a bus access to the counter is in progress |
| load_start_i | input | 1 | Strobe: a load command has been acknowledged, and the next byte is the upper byte |
| load_byte_i | input | 1 | Strobe: a load byte has been acknowledged |
| load_data_i | input | 8 | Byte that goes with load_byte_i |
| count_o | output | 24 | Current count |
| inc_o | output | 1 | High for one cycle when an increment shows on count_o |
| tick_lost_o | output | 1 | Sticky flag: a tick was dropped |

## Verification
The assertions check on every cycle that:
- the count is stable during an access when no byte arrives;
- every increment strobe matches a count exactly one higher and follows a cycle with the access flag low;
- the lost-tick flag only rises on a tick inside an access and never falls outside reset.

Only the bench scenarios can show:
- the deferral and release timing;
- wrap-around;
- the byte order of loads, partial loads and ignored surplus bytes;
- the re-queueing of a tick that coincides with a release.

The bench checks these against a cycle model that it builds from the requirements alone.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] lane_t;
endpackage

// File: rtl/ftc_tick_gate.sv
module ftc_tick_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic access_i,
  output logic inc_req_o,
  output logic lost_o
);
  logic pend_q, pend_d;
  logic lost_q, lost_d;

  // next state
  always_comb begin
    inc_req_o = !access_i && (tick_i || pend_q);
    if (access_i) begin
      pend_d = pend_q || tick_i;
    end else begin
      // a tick coinciding with a release is re-queued
      pend_d = pend_q && tick_i;
    end
    lost_d = lost_q || (access_i && tick_i && pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      lost_q <= lost_d;
    end
  end

  assign lost_o = lost_q;
endmodule

// File: rtl/ftc_load_seq.sv
module ftc_load_seq #(
  parameter int N_LANES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               access_i,
  input  logic               start_i,
  input  logic               byte_i,
  output logic [N_LANES-1:0] lane_we_o
);
  localparam int PTR_W = $clog2(N_LANES + 1);
  localparam logic [PTR_W-1:0] PTR_IDLE = PTR_W'(N_LANES);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             accept;

  assign accept = access_i && byte_i && !start_i && (ptr_q != PTR_IDLE);

  always_comb begin
    ptr_d = ptr_q;
    if (!access_i) begin
      ptr_d = PTR_IDLE;
    end else if (start_i) begin
      ptr_d = '0;
    end else if (accept) begin
      ptr_d = ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= PTR_IDLE;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  for (genvar k = 0; k < N_LANES; k++) begin : g_we
    assign lane_we_o[k] = accept && (ptr_q == PTR_W'(k));
  end
endmodule

// File: rtl/ftc_count_reg.sv
module ftc_count_reg
  import ftc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inc_req_i,
  input  logic [CNT_W/BYTE_W-1:0] lane_we_i,
  input  lane_t                   data_i,
  output logic [CNT_W-1:0]        count_o,
  output logic                    inc_o
);
  localparam int N_LANES = CNT_W / BYTE_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_plus;
  logic             any_load, cnt_en;
  logic             inc_q;

  assign cnt_plus = cnt_q + CNT_W'(1);
  assign any_load = |lane_we_i;
  assign cnt_en   = any_load || inc_req_i;

  // lane 0 is the most significant byte
  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    localparam int HI = CNT_W - 1 - k * BYTE_W;
    always_comb begin
      if (lane_we_i[k]) begin
        cnt_d[HI -: BYTE_W] = data_i;
      end else if (any_load) begin
        cnt_d[HI -: BYTE_W] = cnt_q[HI -: BYTE_W];
      end else begin
        cnt_d[HI -: BYTE_W] = cnt_plus[HI -: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= 1'b0;
    end else begin
      inc_q <= inc_req_i && !any_load;
    end
  end

  assign count_o = cnt_q;
  assign inc_o   = inc_q;
endmodule

// File: rtl/frozen_tick_counter.sv
module frozen_tick_counter
  import ftc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             access_i,
  input  logic             load_start_i,
  input  logic             load_byte_i,
  input  logic [7:0]       load_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             inc_o,
  output logic             tick_lost_o
);
  localparam int N_LANES = CNT_W / BYTE_W;

  logic               inc_req;
  logic [N_LANES-1:0] lane_we;

  ftc_tick_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .access_i  (access_i),
    .inc_req_o (inc_req),
    .lost_o    (tick_lost_o)
  );

  ftc_load_seq #(.N_LANES(N_LANES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .access_i  (access_i),
    .start_i   (load_start_i),
    .byte_i    (load_byte_i),
    .lane_we_o (lane_we)
  );

  ftc_count_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_req_i (inc_req),
    .lane_we_i (lane_we),
    .data_i    (load_data_i),
    .count_o   (count_o),
    .inc_o     (inc_o)
  );
endmodule

// File: rtl/ftc_chk.sv
module ftc_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             access_i,
  input logic             load_byte_i,
  input logic [CNT_W-1:0] count_o,
  input logic             inc_o,
  input logic             tick_lost_o
);
  // R3
  frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access_i && !load_byte_i) |=> $stable(count_o));

  // R2
  inc_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_o |-> (count_o == $past(count_o) + CNT_W'(1)));

  // R4
  inc_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_o |-> !$past(access_i));

  // R5
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_lost_o |=> tick_lost_o);

  // R5
  lost_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_lost_o) |-> $past(access_i && tick_i));
endmodule

bind frozen_tick_counter ftc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .access_i    (access_i),
  .load_byte_i (load_byte_i),
  .count_o     (count_o),
  .inc_o       (inc_o),
  .tick_lost_o (tick_lost_o)
);

// File: tb/frozen_tick_counter_tb.sv
`timescale 1ns/100ps
module frozen_tick_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, acc = 1'b0, st = 1'b0, lb = 1'b0;
  logic [7:0]  dat = 8'h00;
  logic [23:0] count;
  logic        inc, lost;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [23:0] m_cnt;
  logic        m_inc, m_pend, m_lost;
  int          m_ptr;

  always #2.5 clk = ~clk;

  frozen_tick_counter u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .access_i(acc),
    .load_start_i(st), .load_byte_i(lb), .load_data_i(dat),
    .count_o(count), .inc_o(inc), .tick_lost_o(lost)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] put_lane(input logic [23:0] v, input int k, input logic [7:0] d);
    logic [23:0] r = v;
    r[23 - 8*k -: 8] = d;
    return r;
  endfunction

  task automatic model_step();
    bit ok = acc && lb && !st && (m_ptr < 3);
    m_inc = 1'b0;
    if (ok) m_cnt = put_lane(m_cnt, m_ptr, dat);
    else if (!acc && (tick || m_pend)) begin m_cnt = m_cnt + 24'd1; m_inc = 1'b1; end
    m_lost = m_lost || (acc && tick && m_pend);
    m_pend = acc ? (m_pend || tick) : (m_pend && tick);
    if (!acc) m_ptr = 3; else if (st) m_ptr = 0; else if (ok) m_ptr++;
  endtask

  task automatic step(input logic t, input logic a, input logic s, input logic b, input logic [7:0] d);
    @(negedge clk);
    tick = t; acc = a; st = s; lb = b; dat = d;
    @(posedge clk);
    model_step();
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_cnt = 0; m_inc = 0; m_pend = 0; m_lost = 0; m_ptr = 3;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count in reset", count, 24'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 count", count, 24'h0);
    chk("R1 lost", {23'd0, lost}, 24'd0);
    chk("R1 inc", {23'd0, inc}, 24'd0);

    step(1,0,0,0,0); chk("R2 tick", count, 24'h1); chk("R2 inc pulse", {23'd0,inc}, 24'd1);
    step(0,0,0,0,0); chk("R2 inc single", {23'd0,inc}, 24'd0);

    step(0,1,1,0,0);
    step(0,1,0,1,8'hFF); chk("R7 upper byte", count, 24'hFF0001);
    step(0,1,0,1,8'hFF); chk("R7 middle byte", count, 24'hFFFF01);
    step(0,1,0,1,8'hFE); chk("R7 lower byte", count, 24'hFFFFFE);
    step(0,1,0,1,8'h12); chk("R8 fourth byte", count, 24'hFFFFFE);
    step(0,0,0,0,0);
    step(1,0,0,0,0); chk("R2 to max", count, 24'hFFFFFF);
    step(1,0,0,0,0); chk("R2 wrap", count, 24'h000000); chk("R2 wrap inc", {23'd0,inc}, 24'd1);

    step(1,1,0,0,0); chk("R3 frozen", count, 24'h0); chk("R3 no inc", {23'd0,inc}, 24'd0);
    repeat (3) step(0,1,0,0,0);
    chk("R3 still frozen", count, 24'h0);
    step(0,0,0,0,0); chk("R4 release", count, 24'h1); chk("R4 inc", {23'd0,inc}, 24'd1);
    step(0,0,0,0,0); chk("R4 once", count, 24'h1);

    step(0,1,0,1,8'h55); chk("R8 no start", count, 24'h1);
    step(0,0,0,1,8'h55); chk("R8 access low", count, 24'h1);

    step(1,1,0,0,0);
    step(1,1,0,0,0); chk("R5 lost set", {23'd0,lost}, 24'd1);
    step(0,0,0,0,0); chk("R5 one applied", count, 24'h2);
    step(0,0,0,0,0); chk("R5 only one", count, 24'h2); chk("R5 sticky", {23'd0,lost}, 24'd1);

    step(1,1,0,0,0);
    step(0,0,0,0,0); chk("R6 short gap", count, 24'h3);
    step(0,1,0,0,0); chk("R6 held again", count, 24'h3);

    step(1,1,0,0,0);
    step(0,1,1,0,0);
    step(0,1,0,1,8'h00);
    step(0,1,0,1,8'h00);
    step(0,1,0,1,8'h01); chk("R9 loaded", count, 24'h1);
    step(0,0,0,0,0); chk("R9 pending on load", count, 24'h2);

    step(1,1,0,0,0);
    step(1,0,0,0,0); chk("R10 first", count, 24'h3);
    step(0,0,0,0,0); chk("R10 requeued", count, 24'h4); chk("R10 inc", {23'd0,inc}, 24'd1);
    step(0,0,0,0,0); chk("R10 settled", count, 24'h4);

    step(0,1,1,0,0);
    step(0,1,0,1,8'hA9);
    step(0,0,0,0,0); chk("R7 partial load", count, 24'hA90004);

    // constrained random phase against the bench model
    for (int i = 0; i < 3000; i++) begin
      logic a, t, s, b;
      a = ($urandom % 4) != 0 ? acc : ~acc;
      t = ($urandom % 6) == 0;
      s = a && (($urandom % 10) == 0);
      b = ($urandom % 3) == 0;
      step(t, a, s, b, 8'($urandom));
      chk("R2/R7 random count", count, m_cnt);
      chk("R2 random inc", {23'd0,inc}, {23'd0,m_inc});
      chk("R5 random lost", {23'd0,lost}, {23'd0,m_lost});
    end

    @(negedge clk); rst_n = 1'b0; tick = 0; acc = 0; st = 0; lb = 0;
    #1;
    chk("R1 reset count", count, 24'h0);
    chk("R1 reset lost", {23'd0,lost}, 24'd0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule